// File: doc/BRIEF.md
# Configuration table walker

This block is a hardware sequencer that discovers the engines behind a bus slave by walking the slave's configuration table. The table holds 32-bit words. The walker fetches one word at a time through a simple read request/response port and checks a 4-bit CRC carried in each word. It then decodes the word into its fields and keeps a running engine address that grows by the size each entry claims. Ordinary engines are reported as one record each on a valid/ready output. Hub-master entries are noted, and hub-link entries are counted.

A pulse on `start` launches a walk. The walk ends in one of three ways: at the first entry that does not request a successor, at the last index the table page can hold, or at the first CRC mismatch or read error. At the end the block emits a one-cycle completion pulse. The pulse carries the final status, whether a hub master was seen and where its registers sit, and the number of hub links.

Top module: `cfg_table_walker`

## Requirements
- R1: After synchronous reset the block is idle: `busy`, `rd_req_valid`, `rec_valid` and `done_valid` are all low.
- R2: The first entry index is 2. The word for entry i is requested from byte address (i+1)*4, and indices are requested in increasing order, one at a time. A request holds its address until `rd_req_ready` accepts it.
- R3: Every word carries a CRC in bits 3:0, computed over bits 31:4 in 4-bit groups from the most significant group down. The CRC uses polynomial x^4+x^2+x+1 and starts from zero. On a mismatch the walk stops with `done_status` = 1: that word yields no record and no further read is issued.
- R4: A response with `rd_rsp_err` set stops the walk with `done_status` = 2, and no further read is issued.
- R5: Word fields: bit 31 is the continue flag, bits 23:16 the slot count, bits 15:12 the version and bits 11:4 the type. Bits 30:24 are ignored.
- R6: The running engine address starts at 0xC00. After every accepted entry it grows by slots*0x400, whatever the entry's type and whether or not the entry made a record.
- R7: An entry makes a record when its type is not 0, not 0x1C and not 0x1D, and its slot count is not 0. The record carries unit = i, the type, the version, base = running address before the entry, size = slots*0x400, and an interrupt bit index that is 1 for the first record of a walk and grows by one per record.
- R8: A type 0x1C entry sets the hub-seen flag and captures the running address before that entry as the hub register base. Both are reported at completion.
- R9: Each type 0x1D entry increments a link counter. The reported link count is that counter divided by 2, rounded down.
- R10: The walk ends, with `done_status` = 0, after the first entry whose continue flag is 0 has been fully processed (including its record and its effect on the counters).
- R11: Index 255 is the last entry ever read. If its continue flag is 1, the walk still ends with `done_status` = 0.
- R12: A record, once valid, holds all its fields until `rec_ready` accepts it. No read is requested while a record waits.
- R13: `done_valid` is high for exactly one cycle per walk. `busy` is high from the cycle after `start` until completion, and `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only while idle) |
| busy | output | 1 | A walk is in progress |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Byte address of the requested word |
| rd_rsp_valid | input | 1 | Read response present |
| rd_rsp_data | input | 32 | Read response word |
| rd_rsp_err | input | 1 | Read response failed |
| rec_valid | output | 1 | Engine record valid |
| rec_ready | input | 1 | Engine record accepted |
| rec_unit | output | 8 | Table index of the engine |
| rec_type | output | 8 | Engine type |
| rec_version | output | 4 | Engine version |
| rec_base | output | 32 | Engine base address |
| rec_size | output | 32 | Engine address span |
| rec_irq_bit | output | 8 | Interrupt bit index of the engine |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | 0 normal end, 1 CRC mismatch, 2 read error |
| done_hub_seen | output | 1 | A hub-master entry was found |
| done_hub_base | output | 32 | Hub register base address |
| done_link_count | output | 8 | Hub-link entries divided by two |

## Verification
The tables the bench walks include these entries:
- skipped entries with nonzero slots: a design that advanced the address only on records would place every later engine too low;
- a zero-slot engine: a design that forgot that rule would emit a spurious record with size zero;
- an odd number of hub-link entries: a design that dropped the halving, or rounded up, would report the wrong link count;
- a hub master as the very last entry: a design that latched the completion fields one cycle early would miss the flag.

A table with every continue flag set checks that the walk stops at index 255 instead of running past the page. Corrupted CRCs and read errors mid-table check that the abort comes at once, with no extra read and no record from the bad word. Stalled request and record handshakes, plus a stray `start` during a walk, check that addresses stay in sequence and that nothing restarts.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

  typedef enum logic [1:0] {
    WALK_OK       = 2'd0,
    WALK_CRC_ERR  = 2'd1,
    WALK_READ_ERR = 2'd2
  } walk_status_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_PROC,
    ST_EMIT
  } walk_state_e;

  // Meaningful part of a table word; reserved bits are dropped.
  typedef struct packed {
    logic       cont;
    logic [7:0] slots;
    logic [3:0] version;
    logic [7:0] etype;
    logic [3:0] crc;
  } cfg_entry_t;

endpackage

// File: rtl/cfgw_crc4.sv
module cfgw_crc4 #(
  parameter int         NIBBLES = 7,
  parameter logic [3:0] POLY    = 4'h7
) (
  input  logic [4*NIBBLES-1:0] data,
  output logic [3:0]           crc
);

  logic [3:0] acc;

  // Each group is xored into the remainder, which is then advanced by four
  // bit steps modulo x^4 + POLY.
  always_comb begin
    acc = '0;
    for (int n = NIBBLES - 1; n >= 0; n--) begin
      acc = acc ^ data[4*n +: 4];
      for (int b = 0; b < 4; b++) begin
        acc = acc[3] ? ({acc[2:0], 1'b0} ^ POLY) : {acc[2:0], 1'b0};
      end
    end
    crc = acc;
  end

endmodule

// File: rtl/cfgw_decode.sv
module cfgw_decode
  import cfgw_pkg::*;
#(
  parameter logic [7:0] HUB_MASTER_TYPE = 8'h1C,
  parameter logic [7:0] HUB_LINK_TYPE   = 8'h1D
) (
  input  cfg_entry_t entry,
  output logic       cont,
  output logic [7:0] slots,
  output logic [3:0] version,
  output logic [7:0] etype,
  output logic [3:0] crc_field,
  output logic       is_hub_master,
  output logic       is_hub_link,
  output logic       makes_record
);

  logic is_unused;

  assign cont          = entry.cont;
  assign slots         = entry.slots;
  assign version       = entry.version;
  assign etype         = entry.etype;
  assign crc_field     = entry.crc;
  assign is_unused     = (entry.etype == 8'h00);
  assign is_hub_master = (entry.etype == HUB_MASTER_TYPE);
  assign is_hub_link   = (entry.etype == HUB_LINK_TYPE);
  assign makes_record  = !is_unused && !is_hub_master && !is_hub_link &&
                         (entry.slots != 8'h00);

endmodule

// File: rtl/cfg_table_walker.sv
module cfg_table_walker
  import cfgw_pkg::*;
#(
  parameter int          ADDR_W          = 32,
  parameter int          PAGE_BYTES      = 1024,
  parameter int          FIRST_INDEX     = 2,
  parameter int          LAST_INDEX      = 255,
  parameter logic [31:0] BASE_START      = 32'h0000_0C00,
  parameter logic [7:0]  HUB_MASTER_TYPE = 8'h1C,
  parameter logic [7:0]  HUB_LINK_TYPE   = 8'h1D,
  localparam int         IDX_W           = $clog2(LAST_INDEX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [31:0]       rd_rsp_data,
  input  logic              rd_rsp_err,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [IDX_W-1:0]  rec_unit,
  output logic [7:0]        rec_type,
  output logic [3:0]        rec_version,
  output logic [ADDR_W-1:0] rec_base,
  output logic [ADDR_W-1:0] rec_size,
  output logic [IDX_W-1:0]  rec_irq_bit,
  output logic              done_valid,
  output logic [1:0]        done_status,
  output logic              done_hub_seen,
  output logic [ADDR_W-1:0] done_hub_base,
  output logic [IDX_W-1:0]  done_link_count
);

  localparam int PAGE_SHIFT = $clog2(PAGE_BYTES);

  walk_state_e       state;
  logic [IDX_W-1:0]  idx, irq_idx, link_cnt, link_nx;
  logic [ADDR_W-1:0] base, hub_base, hub_base_nx, entry_size;
  logic              hub_seen, hub_seen_nx;
  logic [31:0]       word_q;

  logic              dec_cont, dec_hm, dec_hl, dec_rec;
  logic [7:0]        dec_slots, dec_type;
  logic [3:0]        dec_version, dec_crc, crc_calc;

  logic crc_ok, take_entry, last_entry, advance;
  logic finish_rd, finish_crc, finish_ok, finish;

  cfgw_decode #(
    .HUB_MASTER_TYPE(HUB_MASTER_TYPE),
    .HUB_LINK_TYPE  (HUB_LINK_TYPE)
  ) u_decode (
    .entry        ({word_q[31], word_q[23:0]}),
    .cont         (dec_cont),
    .slots        (dec_slots),
    .version      (dec_version),
    .etype        (dec_type),
    .crc_field    (dec_crc),
    .is_hub_master(dec_hm),
    .is_hub_link  (dec_hl),
    .makes_record (dec_rec)
  );

  cfgw_crc4 #(.NIBBLES(7), .POLY(4'h7)) u_crc (
    .data(word_q[31:4]),
    .crc (crc_calc)
  );

  assign busy         = (state != ST_IDLE);
  assign rd_req_valid = (state == ST_REQ);
  assign rd_req_addr  = (ADDR_W'(idx) + ADDR_W'(1)) << 2;

  assign crc_ok      = (crc_calc == dec_crc);
  assign take_entry  = (state == ST_PROC) && crc_ok;
  assign entry_size  = ADDR_W'(dec_slots) << PAGE_SHIFT;
  assign last_entry  = !dec_cont || (idx == IDX_W'(LAST_INDEX));
  assign advance     = (take_entry && !dec_rec) || ((state == ST_EMIT) && rec_ready);

  // Values including the entry being processed, so the final entry counts.
  assign hub_seen_nx = hub_seen | (take_entry & dec_hm);
  assign hub_base_nx = (take_entry && dec_hm) ? base : hub_base;
  assign link_nx     = link_cnt + IDX_W'(take_entry && dec_hl);

  assign finish_rd  = (state == ST_WAIT) && rd_rsp_valid && rd_rsp_err;
  assign finish_crc = (state == ST_PROC) && !crc_ok;
  assign finish_ok  = advance && last_entry;
  assign finish     = finish_rd || finish_crc || finish_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      idx             <= '0;
      irq_idx         <= '0;
      link_cnt        <= '0;
      base            <= '0;
      hub_base        <= '0;
      hub_seen        <= 1'b0;
      word_q          <= '0;
      rec_valid       <= 1'b0;
      rec_unit        <= '0;
      rec_type        <= '0;
      rec_version     <= '0;
      rec_base        <= '0;
      rec_size        <= '0;
      rec_irq_bit     <= '0;
      done_valid      <= 1'b0;
      done_status     <= WALK_OK;
      done_hub_seen   <= 1'b0;
      done_hub_base   <= '0;
      done_link_count <= '0;
    end else begin
      done_valid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          idx      <= IDX_W'(FIRST_INDEX);
          base     <= ADDR_W'(BASE_START);
          irq_idx  <= IDX_W'(1);
          link_cnt <= '0;
          hub_seen <= 1'b0;
          hub_base <= '0;
          state    <= ST_REQ;
        end
        ST_REQ: if (rd_req_ready) state <= ST_WAIT;
        ST_WAIT: if (rd_rsp_valid && !rd_rsp_err) begin
          word_q <= rd_rsp_data;
          state  <= ST_PROC;
        end
        ST_PROC: if (take_entry && dec_rec) begin
          rec_valid   <= 1'b1;
          rec_unit    <= idx;
          rec_type    <= dec_type;
          rec_version <= dec_version;
          rec_base    <= base;
          rec_size    <= entry_size;
          rec_irq_bit <= irq_idx;
          irq_idx     <= irq_idx + 1'b1;
          state       <= ST_EMIT;
        end
        ST_EMIT: if (rec_ready) rec_valid <= 1'b0;
        default: state <= ST_IDLE;
      endcase

      if (take_entry) begin
        hub_seen <= hub_seen_nx;
        hub_base <= hub_base_nx;
        link_cnt <= link_nx;
      end

      if (advance) begin
        base <= base + entry_size;
        if (!last_entry) begin
          idx   <= idx + 1'b1;
          state <= ST_REQ;
        end
      end

      if (finish) begin
        state           <= ST_IDLE;
        done_valid      <= 1'b1;
        done_status     <= finish_rd ? WALK_READ_ERR : (finish_crc ? WALK_CRC_ERR : WALK_OK);
        done_hub_seen   <= hub_seen_nx;
        done_hub_base   <= hub_base_nx;
        done_link_count <= link_nx >> 1;
      end
    end
  end

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  assert_crc_abort_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PROC) && (crc_calc != dec_crc) |=>
      done_valid && (done_status == WALK_CRC_ERR) && !rd_req_valid);

  assert_addr_bound_R11: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> (rd_req_addr >= ADDR_W'((FIRST_INDEX + 1) * 4)) &&
                     (rd_req_addr <= ADDR_W'((LAST_INDEX + 1) * 4)));

  assert_rec_hold_R12: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_base) &&
      $stable(rec_unit) && $stable(rec_size) && $stable(rec_irq_bit));

  assert_no_read_with_rec_R12: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> !rd_req_valid);

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  assert_idle_after_done_R13: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> !busy);

endmodule

// File: tb/tb_cfg_table_walker.sv
module tb_cfg_table_walker;

  localparam int CLK_PERIOD = 10;

  logic        clk, rst, start, busy;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_err;
  logic [31:0] rd_req_addr, rd_rsp_data;
  logic        rec_valid, rec_ready;
  logic [7:0]  rec_unit, rec_type, rec_irq_bit;
  logic [3:0]  rec_version;
  logic [31:0] rec_base, rec_size;
  logic        done_valid, done_hub_seen;
  logic [1:0]  done_status;
  logic [31:0] done_hub_base;
  logic [7:0]  done_link_count;

  cfg_table_walker dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data), .rd_rsp_err(rd_rsp_err),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_unit(rec_unit), .rec_type(rec_type),
    .rec_version(rec_version), .rec_base(rec_base), .rec_size(rec_size),
    .rec_irq_bit(rec_irq_bit), .done_valid(done_valid), .done_status(done_status),
    .done_hub_seen(done_hub_seen), .done_hub_base(done_hub_base),
    .done_link_count(done_link_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    int          unit;
    int          etype;
    int          ver;
    logic [31:0] base;
    logic [31:0] size;
    int          irq;
  } rec_t;

  logic [31:0] mem [0:256];
  rec_t        exp_q[$];
  int          err_idx;
  int          exp_status, exp_links, exp_reads;
  bit          exp_hub;
  logic [31:0] exp_hub_base;
  int          checks, errors, reads_seen, done_seen, exp_next_idx;
  bit          stall_req, stall_rec, finished;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bit-serial reference: polynomial x^4+x^2+x+1, zero start, MSB first.
  function automatic logic [3:0] ref_crc(logic [27:0] d);
    logic [3:0] c = 4'h0;
    for (int k = 27; k >= 0; k--) begin
      logic fb;
      fb = c[3] ^ d[k];
      c  = {c[2:0], 1'b0};
      if (fb) c = c ^ 4'h7;
    end
    return c;
  endfunction

  function automatic logic [31:0] mk(bit cont, int slots, int ver, int etype);
    logic [31:0] w;
    w = {cont, 7'd0, slots[7:0], ver[3:0], etype[7:0], 4'd0};
    w[3:0] = ref_crc(w[31:4]);
    return w;
  endfunction

  task automatic clear_mem();
    for (int k = 0; k <= 256; k++) mem[k] = 32'h0;
    err_idx = -1;
  endtask

  // Expected results from the requirements alone.
  task automatic model();
    int          idx   = 2;
    logic [31:0] base  = 32'hC00;
    int          irq   = 1;
    int          links = 0;
    exp_q.delete();
    exp_status = 0; exp_hub = 1'b0; exp_hub_base = 32'h0; exp_reads = 0;
    for (int k = 0; k < 1000; k++) begin
      logic [31:0] w;
      int          slots, ty;
      exp_reads++;
      if (idx == err_idx) begin exp_status = 2; break; end
      w = mem[idx + 1];
      if (ref_crc(w[31:4]) != w[3:0]) begin exp_status = 1; break; end
      slots = int'(w[23:16]);
      ty    = int'(w[11:4]);
      if (ty == 28) begin
        exp_hub = 1'b1; exp_hub_base = base;
      end else if (ty == 29) begin
        links++;
      end else if (ty != 0 && slots != 0) begin
        rec_t r;
        r.unit = idx; r.etype = ty; r.ver = int'(w[15:12]);
        r.base = base; r.size = slots * 1024; r.irq = irq;
        exp_q.push_back(r);
        irq++;
      end
      base = base + slots * 1024;
      if (!w[31] || idx == 255) break;
      idx++;
    end
    exp_links = links / 2;
  endtask

  // Read responder: one-cycle latency, optional request stalls.
  initial begin
    bit          pend = 1'b0;
    logic [31:0] paddr = 32'h0;
    int          cyc = 0;
    rd_req_ready = 1'b1; rd_rsp_valid = 1'b0; rd_rsp_data = 32'h0; rd_rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (pend) begin
        int widx;
        widx = int'(paddr >> 2);
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = (widx <= 256) ? mem[widx] : 32'h0;
        rd_rsp_err   = ((widx - 1) == err_idx);
        pend = 1'b0;
      end else begin
        rd_rsp_valid = 1'b0;
        rd_rsp_err   = 1'b0;
      end
      rd_req_ready = stall_req ? ((cyc % 3) == 0) : 1'b1;
      if (rd_req_valid && rd_req_ready) begin
        check(rd_req_addr == 32'((exp_next_idx + 1) * 4), "R2", "read address",
              rd_req_addr, 32'((exp_next_idx + 1) * 4));
        check(!rec_valid, "R12", "read while record pending", 32'(rec_valid), 32'h0);
        exp_next_idx++;
        reads_seen++;
        pend  = 1'b1;
        paddr = rd_req_addr;
      end
    end
  end

  // Monitor: scoreboard for records and completion.
  initial begin
    int mcyc = 0;
    rec_ready = 1'b1;
    forever begin
      @(negedge clk);
      mcyc++;
      rec_ready = stall_rec ? ((mcyc % 4) == 0) : 1'b1;
      if (rec_valid && rec_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected record unit", 32'(rec_unit), 32'h0);
        end else begin
          rec_t r;
          r = exp_q.pop_front();
          check(rec_unit == 8'(r.unit), "R7", "unit", 32'(rec_unit), 32'(r.unit));
          check(rec_type == 8'(r.etype), "R5", "type", 32'(rec_type), 32'(r.etype));
          check(rec_version == 4'(r.ver), "R5", "version", 32'(rec_version), 32'(r.ver));
          check(rec_base == r.base, "R6", "base", rec_base, r.base);
          check(rec_size == r.size, "R7", "size", rec_size, r.size);
          check(rec_irq_bit == 8'(r.irq), "R7", "irq bit", 32'(rec_irq_bit), 32'(r.irq));
        end
      end
      if (done_valid) begin
        string tag;
        tag = (exp_status == 1) ? "R3" : ((exp_status == 2) ? "R4" : "R10");
        done_seen++;
        check(done_status == 2'(exp_status), tag, "status", 32'(done_status), 32'(exp_status));
        check(done_hub_seen == exp_hub, "R8", "hub seen", 32'(done_hub_seen), 32'(exp_hub));
        check(done_hub_base == exp_hub_base, "R8", "hub base", done_hub_base, exp_hub_base);
        check(done_link_count == 8'(exp_links), "R9", "link count",
              32'(done_link_count), 32'(exp_links));
      end
    end
  end

  task automatic run_walk(bit sreq, bit srec, bit poke);
    model();
    stall_req = sreq; stall_rec = srec;
    reads_seen = 0; done_seen = 0; exp_next_idx = 2;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R13", "busy after start", 32'(busy), 32'h1);
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (done_seen == 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(reads_seen == exp_reads, "R10 R13", "read count", 32'(reads_seen), 32'(exp_reads));
    check(exp_q.size() == 0, "R7", "records missing", 32'(exp_q.size()), 32'h0);
    check(done_seen == 1, "R13", "done pulses", 32'(done_seen), 32'h1);
    check(busy == 1'b0, "R13", "idle after done", 32'(busy), 32'h0);
  endtask

  task automatic load_mixed();
    clear_mem();
    mem[3]  = mk(1, 1, 2, 8'h10);
    mem[4]  = mk(1, 2, 0, 8'h00);
    mem[5]  = mk(1, 1, 1, 8'h1C);
    mem[6]  = mk(1, 1, 0, 8'h1D);
    mem[7]  = mk(1, 1, 0, 8'h1D);
    mem[8]  = mk(1, 1, 0, 8'h1D);
    mem[9]  = mk(1, 0, 3, 8'h22);
    mem[10] = mk(1, 4, 5, 8'h33) | 32'h7F00_0000 ^ 32'h7F00_0000;
    mem[11] = mk(0, 1, 1, 8'h44);
    mem[12] = mk(1, 1, 1, 8'h55);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 1'b0;
    stall_req = 1'b0; stall_rec = 1'b0;
    reads_seen = 0; done_seen = 0; exp_next_idx = 2;
    clear_mem();
    rst = 1'b1; start = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0; start = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check(busy == 1'b0, "R1", "busy", 32'(busy), 32'h0);
    check(rd_req_valid == 1'b0, "R1", "rd_req_valid", 32'(rd_req_valid), 32'h0);
    check(rec_valid == 1'b0, "R1", "rec_valid", 32'(rec_valid), 32'h0);
    check(done_valid == 1'b0, "R1", "done_valid", 32'(done_valid), 32'h0);

    // Mixed table, R6 R7 R8 R9 R10; reserved bits 30:24 set in one word (R5)
    load_mixed();
    mem[10] = mk(1, 4, 5, 8'h33);
    mem[10][30:24] = 7'h55;
    run_walk(1'b0, 1'b0, 1'b0);
    // Same with stalls and a stray start (R12 R13)
    run_walk(1'b1, 1'b1, 1'b1);

    // CRC error mid-table (R3)
    load_mixed();
    mem[7] = mem[7] ^ 32'h1;
    run_walk(1'b0, 1'b0, 1'b0);

    // Read error (R4)
    load_mixed();
    err_idx = 4;
    run_walk(1'b1, 1'b0, 1'b0);

    // Full page, all continue flags set (R11)
    clear_mem();
    for (int i = 2; i <= 255; i++) begin
      if (i % 5 == 0) mem[i + 1] = mk(1, 1, i % 16, 8'h40);
      else if (i % 7 == 0) mem[i + 1] = mk(1, 1, 0, 8'h1D);
      else mem[i + 1] = mk(1, 0, 0, 8'h00);
    end
    run_walk(1'b0, 1'b1, 1'b0);
    check(reads_seen == 254, "R11", "reads on full page", 32'(reads_seen), 32'd254);

    // Hub master as the final entry; single hub link rounds down (R8 R9 R10)
    clear_mem();
    mem[3] = mk(1, 1, 0, 8'h1D);
    mem[4] = mk(0, 2, 0, 8'h1C);
    run_walk(1'b0, 1'b0, 1'b0);

    // First entry ends the walk (R10)
    clear_mem();
    mem[3] = mk(0, 3, 9, 8'h21);
    run_walk(1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule